// File: doc/BRIEF.md
# Slot-Weighted Dispatch Group Former

This block follows the filling of one instruction dispatch group as instructions are handed to it one at a time. Each instruction arrives with a class code, a flag saying that it also records a condition result, a branch flag, a load flag, its own tag and up to two dependency tags. The dependency tags are a memory-ordering store predecessor and a data predecessor that writes the special count register. The block charges the instruction a slot cost, starts a new group when the instruction has to lead one, and closes the group when it is full or holds a second branch.

Before an instruction is committed, the block reports whether it would collide with a member of the current group. That happens for a load behind a store in the group, and for a branch behind a count-register write in the group. It also reports how many padding no-ops should go in front of the instruction. The caller commits instructions with `ins_fire` and padding no-ops with `nop_fire`. A mode input selects between one group-terminating no-op and plain one-slot no-ops.

The group is tracked by a three-state machine. EMPTY holds no slots. FILL holds 1 to 5 slots. SEALED holds all 6 slots, which only a plain no-op can reach. The state is recomputed from the next slot count:
- to EMPTY on reset or on any closing event;
- to SEALED when a plain no-op brings the count to 6;
- to FILL otherwise.

Top module: `dispatch_group_former`

## Requirements
- R1: After a synchronous reset `slot_cnt` is 0 and `br_held` is 0. The group holds no members, so no dependency tag produces a hazard.
- R2: The slot cost comes from `ins_cls`. Code 1 (divide) costs 2 and code 2 (update-form load/store) costs 2. Code 3 (indexed update), code 4 (reserve load / conditional store) and code 5 (move to condition register) cost 4. Code 6 (condition-register logical), code 7 (special-register move) and every other code cost 1.
- R3: A class whose cost would be 1 costs 2 when `ins_rec` is set. `ins_rec` leaves costs of 2 or 4 unchanged.
- R4: An instruction that costs more than 1 slot, or has class 6 or 7, must lead a group. If it is committed while `slot_cnt` is nonzero, the slot count, the branch mark and all group members are dropped first, and then it is charged.
- R5: An instruction committed while `slot_cnt` is 5 or 6 closes the group. The counters go to 0 and the instruction is neither charged nor recorded as a member.
- R6: A branch committed while `br_held` is 1 closes the group the same way. Otherwise a committed branch sets `br_held`.
- R7: `hazard` is 1 when `ins_load` and `st_dep_vld` are set and `st_dep_tag` equals the tag of a committed instruction in the current group.
- R8: `hazard` is 1 when `ins_br` and `ctr_dep_vld` are set and `ctr_dep_tag` equals the tag of a committed instruction in the current group. `hazard` and `pad_cnt` follow the presented fields without `ins_fire`, and they change no state.
- R9: `pad_cnt` is 0 when there is no hazard or when `slot_cnt` is 6. On a hazard it is 1 when `term_mode` is 1, and 5 minus `slot_cnt` when `term_mode` is 0.
- R10: A committed no-op closes the group when `term_mode` is 1 or `slot_cnt` is 6. Otherwise it adds one slot, and that slot matches no dependency tag.
- R11: When `ins_fire` and `nop_fire` are both 1, only the instruction is committed and the no-op is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_fire | input | 1 | Commit the presented instruction |
| ins_cls | input | 4 | Class code of the instruction |
| ins_rec | input | 1 | Instruction also records a condition result |
| ins_br | input | 1 | Instruction is a branch |
| ins_load | input | 1 | Instruction reads memory |
| ins_tag | input | TAG_W | Tag of the instruction |
| st_dep_vld | input | 1 | A memory-ordering store predecessor exists |
| st_dep_tag | input | TAG_W | Tag of that store predecessor |
| ctr_dep_vld | input | 1 | A count-register-writing data predecessor exists |
| ctr_dep_tag | input | TAG_W | Tag of that predecessor |
| nop_fire | input | 1 | Commit one padding no-op |
| term_mode | input | 1 | No-ops terminate the group |
| hazard | output | 1 | Presented instruction collides with the current group |
| pad_cnt | output | 3 | No-ops to insert before the instruction |
| slot_cnt | output | 3 | Slots used in the current group |
| br_held | output | 1 | The current group already holds a branch |

## Verification
The cost table is tried with each class code committed into an empty group, so that a wrong cost shows directly in `slot_cnt`. The group-lead rule is then tried by committing the same classes behind a partly filled group, which tells a clearing restart apart from simple accumulation. Hazard probes vary one input at a time: tag match or not, load/branch flag, dependency valid bit and mode. This separates a real membership match from a stale or padded entry, and the one-no-op pad count from the fill-to-five pad count. Filling to 5 and padding to 6 exercise both closing paths and the zero-pad case at a full group.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
    typedef enum logic [3:0] {
        CLS_PLAIN   = 4'd0,
        CLS_DIVIDE  = 4'd1,
        CLS_MEM_UPD = 4'd2,
        CLS_MEM_IDX = 4'd3,
        CLS_RESERVE = 4'd4,
        CLS_CR_MOVE = 4'd5,
        CLS_CR_LOGIC = 4'd6,
        CLS_SPR_MOVE = 4'd7
    } cls_e;

    typedef enum logic [1:0] {
        GS_EMPTY  = 2'd0,
        GS_FILL   = 2'd1,
        GS_SEALED = 2'd2
    } grp_state_e;
endpackage

// File: rtl/dgf_cost.sv
module dgf_cost #(
    parameter int CW = 3
) (
    input  logic [3:0]    cls,
    input  logic          rec,
    output logic [CW-1:0] cost,
    output logic          lead
);
    import dgf_pkg::*;

    logic [CW-1:0] base;
    logic          lead_cls;

    always_comb begin
        base     = CW'(1);
        lead_cls = 1'b0;
        case (cls)
            CLS_DIVIDE, CLS_MEM_UPD:               base = CW'(2);
            CLS_MEM_IDX, CLS_RESERVE, CLS_CR_MOVE: base = CW'(4);
            CLS_CR_LOGIC, CLS_SPR_MOVE:            lead_cls = 1'b1;
            default:                               base = CW'(1);
        endcase
    end

    // R3: the record flag lifts a one-slot cost to two
    assign cost = (base == CW'(1) && rec) ? CW'(2) : base;
    // R4: multi-slot instructions and two special classes lead a group
    assign lead = lead_cls || (cost != CW'(1));
endmodule

// File: rtl/dgf_tags.sv
module dgf_tags #(
    parameter int NENT  = 6,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic             push_real,
    input  logic [TAG_W-1:0] push_tag,
    input  logic [TAG_W-1:0] qa_tag,
    input  logic [TAG_W-1:0] qb_tag,
    output logic             hit_a,
    output logic             hit_b
);
    localparam int FW = $clog2(NENT + 1);

    logic [TAG_W-1:0] tag_q [NENT];
    logic [NENT-1:0]  vld_q;
    logic [FW-1:0]    fill_q;
    logic [FW-1:0]    wr_idx;
    logic [NENT-1:0]  match_a, match_b;

    assign wr_idx = clr ? '0 : fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            fill_q <= '0;
        end else begin
            if (clr) vld_q <= '0;
            if (push) begin
                vld_q[wr_idx] <= push_real;
                tag_q[wr_idx] <= push_tag;
            end
            fill_q <= wr_idx + FW'(push);
        end
    end

    for (genvar i = 0; i < NENT; i++) begin : g_cmp
        assign match_a[i] = vld_q[i] && (tag_q[i] == qa_tag);
        assign match_b[i] = vld_q[i] && (tag_q[i] == qb_tag);
    end

    assign hit_a = |match_a;
    assign hit_b = |match_b;

    // R5
    tag_room_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !clr) |-> (fill_q < FW'(NENT)));
endmodule

// File: rtl/dispatch_group_former.sv
module dispatch_group_former #(
    parameter int TAG_W     = 6,
    parameter int GRP_SLOTS = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_fire,
    input  logic [3:0]       ins_cls,
    input  logic             ins_rec,
    input  logic             ins_br,
    input  logic             ins_load,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic             st_dep_vld,
    input  logic [TAG_W-1:0] st_dep_tag,
    input  logic             ctr_dep_vld,
    input  logic [TAG_W-1:0] ctr_dep_tag,
    input  logic             nop_fire,
    input  logic             term_mode,
    output logic             hazard,
    output logic [2:0]       pad_cnt,
    output logic [2:0]       slot_cnt,
    output logic             br_held
);
    import dgf_pkg::*;

    localparam int SLOT_W = 3;
    localparam logic [SLOT_W-1:0] FULL     = SLOT_W'(GRP_SLOTS);
    localparam logic [SLOT_W-1:0] CLOSE_AT = SLOT_W'(GRP_SLOTS - 1);

    grp_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d, cost;
    logic              br_q, br_d, lead;
    logic              clr, push, push_real, hit_st, hit_ctr;

    dgf_cost #(.CW(SLOT_W)) u_cost (
        .cls(ins_cls), .rec(ins_rec), .cost(cost), .lead(lead)
    );

    dgf_tags #(.NENT(GRP_SLOTS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst), .clr(clr), .push(push), .push_real(push_real),
        .push_tag(ins_tag), .qa_tag(st_dep_tag), .qb_tag(ctr_dep_tag),
        .hit_a(hit_st), .hit_b(hit_ctr)
    );

    // next-state: slot charging, group closing, membership updates
    always_comb begin
        slot_d    = slot_q;
        br_d      = br_q;
        clr       = 1'b0;
        push      = 1'b0;
        push_real = 1'b0;
        if (ins_fire) begin
            if (slot_q >= CLOSE_AT || (ins_br && br_q)) begin
                clr    = 1'b1;
                slot_d = '0;
                br_d   = 1'b0;
            end else begin
                if (lead && slot_q != '0) begin
                    clr    = 1'b1;
                    slot_d = cost;
                    br_d   = ins_br;
                end else begin
                    slot_d = slot_q + cost;
                    br_d   = br_q | ins_br;
                end
                push      = 1'b1;
                push_real = 1'b1;
            end
        end else if (nop_fire) begin
            if (term_mode || slot_q == FULL) begin
                clr    = 1'b1;
                slot_d = '0;
                br_d   = 1'b0;
            end else begin
                slot_d = slot_q + SLOT_W'(1);
                push   = 1'b1;
            end
        end
        if (slot_d == '0)        state_d = GS_EMPTY;
        else if (slot_d == FULL) state_d = GS_SEALED;
        else                     state_d = GS_FILL;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GS_EMPTY;
            slot_q  <= '0;
            br_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            br_q    <= br_d;
        end
    end

    // outputs
    always_comb begin
        hazard  = (ins_load && st_dep_vld && hit_st) ||
                  (ins_br && ctr_dep_vld && hit_ctr);
        pad_cnt = '0;
        unique case (state_q)
            GS_SEALED: pad_cnt = '0;
            GS_EMPTY, GS_FILL: begin
                if (hazard) pad_cnt = term_mode ? 3'd1 : (CLOSE_AT - slot_q);
            end
            default: pad_cnt = '0;
        endcase
    end

    assign slot_cnt = slot_q;
    assign br_held  = br_q;

    // R10
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot_q <= FULL);
    // R5
    close_full_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_fire && slot_q >= CLOSE_AT) |=> (slot_q == '0 && !br_q));
    // R6
    br_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_fire && ins_br && br_q) |=> (slot_q == '0));
    // R4
    first_open_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_fire && lead && slot_q < CLOSE_AT && !(ins_br && br_q))
        |=> (slot_q == $past(cost)));
    // R10
    nop_term_chk: assert property (@(posedge clk) disable iff (rst)
        (nop_fire && !ins_fire && term_mode) |=> (slot_q == '0));
    // R10
    nop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (nop_fire && !ins_fire && !term_mode && slot_q < FULL)
        |=> (slot_q == $past(slot_q) + SLOT_W'(1)));
endmodule

// File: tb/dispatch_group_former_tb_top.sv
module dispatch_group_former_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ins_fire = 0, ins_rec = 0, ins_br = 0, ins_load = 0;
    logic [3:0] ins_cls = 0;
    logic [5:0] ins_tag = 0, st_dep_tag = 0, ctr_dep_tag = 0;
    logic       st_dep_vld = 0, ctr_dep_vld = 0, nop_fire = 0, term_mode = 0;
    logic       hazard, br_held;
    logic [2:0] pad_cnt, slot_cnt;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dispatch_group_former dut_i (
        .clk(clk), .rst(rst), .ins_fire(ins_fire), .ins_cls(ins_cls),
        .ins_rec(ins_rec), .ins_br(ins_br), .ins_load(ins_load),
        .ins_tag(ins_tag), .st_dep_vld(st_dep_vld), .st_dep_tag(st_dep_tag),
        .ctr_dep_vld(ctr_dep_vld), .ctr_dep_tag(ctr_dep_tag),
        .nop_fire(nop_fire), .term_mode(term_mode), .hazard(hazard),
        .pad_cnt(pad_cnt), .slot_cnt(slot_cnt), .br_held(br_held)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ins_fire = 0; nop_fire = 0; st_dep_vld = 0; ctr_dep_vld = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fire(input int cls, input bit rec, input bit br, input int tag);
        @(negedge clk);
        ins_cls = 4'(cls); ins_rec = rec; ins_br = br; ins_load = 0;
        ins_tag = 6'(tag); st_dep_vld = 0; ctr_dep_vld = 0; ins_fire = 1;
        @(negedge clk);
        ins_fire = 0; ins_rec = 0; ins_br = 0;
    endtask

    task automatic nop(input bit term);
        @(negedge clk);
        term_mode = term; nop_fire = 1;
        @(negedge clk);
        nop_fire = 0; term_mode = 0;
    endtask

    task automatic probe(input bit ld, input bit br, input bit sv, input int st,
                         input bit cv, input int ct, input bit term);
        @(negedge clk);
        ins_load = ld; ins_br = br; st_dep_vld = sv; st_dep_tag = 6'(st);
        ctr_dep_vld = cv; ctr_dep_tag = 6'(ct); term_mode = term; ins_fire = 0;
        #2;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 slot", int'(slot_cnt), 0);
        chk("R1 branch", int'(br_held), 0);
        probe(1, 0, 1, 0, 0, 0, 0);
        chk("R1 no member", int'(hazard), 0);
    endtask

    task automatic t_cost();
        int cls_l [9] = '{0, 1, 2, 3, 4, 5, 6, 7, 15};
        int exp_l [9] = '{1, 2, 2, 4, 4, 4, 1, 1, 1};
        for (int i = 0; i < 9; i++) begin
            do_reset();
            fire(cls_l[i], 0, 0, 1);
            chk($sformatf("R2 cost class %0d", cls_l[i]), int'(slot_cnt), exp_l[i]);
        end
    endtask

    task automatic t_rec();
        do_reset(); fire(0, 1, 0, 1);
        chk("R3 plain rec", int'(slot_cnt), 2);
        do_reset(); fire(6, 1, 0, 1);
        chk("R3 cr logic rec", int'(slot_cnt), 2);
        do_reset(); fire(3, 1, 0, 1);
        chk("R3 rec on cost 4", int'(slot_cnt), 4);
    endtask

    task automatic t_first();
        do_reset();
        fire(0, 0, 0, 2); fire(0, 0, 0, 3);
        chk("R4 before", int'(slot_cnt), 2);
        fire(1, 0, 0, 4);
        chk("R4 divide restarts", int'(slot_cnt), 2);
        probe(1, 0, 1, 2, 0, 0, 0);
        chk("R4 old member dropped", int'(hazard), 0);
        probe(1, 0, 1, 4, 0, 0, 0);
        chk("R4 new member kept", int'(hazard), 1);
        chk("R9 pad after restart", int'(pad_cnt), 3);
        do_reset(); fire(0, 0, 0, 1); fire(7, 0, 0, 2);
        chk("R4 spr move restarts", int'(slot_cnt), 1);
        do_reset(); fire(0, 0, 0, 1); fire(0, 1, 0, 2);
        chk("R4 rec restarts", int'(slot_cnt), 2);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 1; i <= 5; i++) fire(0, 0, 0, i);
        chk("R5 filled", int'(slot_cnt), 5);
        fire(0, 0, 0, 9);
        chk("R5 close slot", int'(slot_cnt), 0);
        probe(1, 0, 1, 9, 0, 0, 0);
        chk("R5 closer not member", int'(hazard), 0);
        probe(1, 0, 1, 1, 0, 0, 0);
        chk("R5 old member gone", int'(hazard), 0);
        do_reset();
        for (int i = 1; i <= 5; i++) fire(0, 0, 0, i);
        nop(0);
        chk("R10 pad to 6", int'(slot_cnt), 6);
        probe(1, 0, 1, 1, 0, 0, 0);
        chk("R7 hazard at 6", int'(hazard), 1);
        chk("R9 no pad at 6", int'(pad_cnt), 0);
        fire(0, 0, 0, 8);
        chk("R5 close from 6", int'(slot_cnt), 0);
    endtask

    task automatic t_branch();
        do_reset();
        fire(0, 0, 1, 1);
        chk("R6 one branch slot", int'(slot_cnt), 1);
        chk("R6 branch held", int'(br_held), 1);
        fire(0, 0, 0, 2);
        fire(0, 0, 1, 3);
        chk("R6 second branch closes", int'(slot_cnt), 0);
        chk("R6 branch cleared", int'(br_held), 0);
        fire(0, 0, 1, 4);
        chk("R6 branch reopens", int'(slot_cnt), 1);
    endtask

    task automatic t_load();
        do_reset();
        fire(0, 0, 0, 3);
        probe(1, 0, 1, 3, 0, 0, 0);
        chk("R7 load hit", int'(hazard), 1);
        chk("R9 fill pad", int'(pad_cnt), 4);
        probe(1, 0, 1, 3, 0, 0, 1);
        chk("R9 term pad", int'(pad_cnt), 1);
        probe(1, 0, 1, 8, 0, 0, 0);
        chk("R7 other tag", int'(hazard), 0);
        probe(0, 0, 1, 3, 0, 0, 0);
        chk("R7 not load", int'(hazard), 0);
        chk("R9 no hazard no pad", int'(pad_cnt), 0);
        probe(1, 0, 0, 3, 0, 0, 0);
        chk("R7 dep invalid", int'(hazard), 0);
        chk("R8 probe keeps state", int'(slot_cnt), 1);
    endtask

    task automatic t_ctr();
        do_reset();
        fire(7, 0, 0, 5);
        probe(0, 1, 0, 0, 1, 5, 0);
        chk("R8 branch hit", int'(hazard), 1);
        chk("R9 branch pad", int'(pad_cnt), 4);
        probe(0, 0, 0, 0, 1, 5, 0);
        chk("R8 not branch", int'(hazard), 0);
        probe(0, 1, 0, 0, 1, 6, 0);
        chk("R8 other tag", int'(hazard), 0);
        probe(0, 1, 1, 5, 0, 0, 0);
        chk("R8 store dep on branch", int'(hazard), 0);
    endtask

    task automatic t_nop();
        do_reset();
        fire(0, 0, 0, 1);
        nop(0);
        chk("R10 plain nop", int'(slot_cnt), 2);
        nop(1);
        chk("R10 term nop", int'(slot_cnt), 0);
        do_reset();
        @(negedge clk); ins_tag = 6'd7;
        nop(0);
        probe(1, 0, 1, 7, 0, 0, 0);
        chk("R10 nop slot no match", int'(hazard), 0);
        do_reset();
        for (int i = 1; i <= 5; i++) fire(0, 0, 0, i);
        nop(0); nop(0);
        chk("R10 nop at 6 closes", int'(slot_cnt), 0);
    endtask

    task automatic t_both();
        do_reset();
        @(negedge clk);
        ins_cls = 4'd1; ins_rec = 0; ins_br = 0; ins_tag = 6'd2;
        term_mode = 1; ins_fire = 1; nop_fire = 1;
        @(negedge clk);
        ins_fire = 0; nop_fire = 0; term_mode = 0;
        chk("R11 nop ignored", int'(slot_cnt), 2);
    endtask

    initial begin
        t_reset(); t_cost(); t_rec(); t_first(); t_full();
        t_branch(); t_load(); t_ctr(); t_nop(); t_both();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule